// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of an SDRAM interface one clock at a time and names the command present in each cycle. It keeps an open/closed flag for each of the four banks and a record of the bank that owns the burst now in flight. With these it judges whether each command suits the state of the bank it targets, and it reports the cycles in which banks begin to precharge. Precharges come from explicit commands, from auto-precharge bursts that run to their end, and from auto-precharge bursts cut short by an access to a different bank.

It is meant to sit beside a controller or a memory model as a protocol monitor. The decoded command, the illegal flag and the precharge event are combinational and belong to the cycle of the pins. Bank state and burst ownership are registered and show the effect of a command from the following cycle. A burst occupies the `BURST_LEN` cycles that follow its READ or WRITE. An illegal command leaves all state untouched.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `csN` low, the pins {rasN,casN,weN} decode as: 011 ACTIVE (cmdOut=1), 101 READ (2), 100 WRITE (3), 110 BURST TERMINATE (4), 010 PRECHARGE (5), 001 AUTO REFRESH (6), 000 MODE REGISTER SET (7), 111 NOP (0). With `csN` high, cmdOut is 0 and cmdIllegal is low, whatever the other pins hold.
- R2: ACTIVE to a closed bank sets its bankActive bit from the next cycle. ACTIVE to an open bank raises cmdIllegal and changes no state.
- R3: READ or WRITE is illegal when the bank at `bankAddr` is closed, or when that bank owns an auto-precharge burst in flight. An illegal access raises cmdIllegal and leaves the burst record and the bank state unchanged.
- R4: A legal READ or WRITE starts a burst. burstValid is high and burstBank shows the bank for the `BURST_LEN` cycles after the command. A10 high on the command selects auto precharge.
- R5: An auto-precharge burst that runs its full length raises the prechargeEvt bit of its bank in the last burst cycle. From the next cycle the bank is closed and burstValid is low.
- R6: BURST TERMINATE ends the burst in flight from the next cycle, whatever `bankAddr` holds. It leaves every bank open and raises no precharge event.
- R7: PRECHARGE with A10 low closes the bank at `bankAddr` and raises its prechargeEvt bit only if that bank was open. PRECHARGE with A10 high closes all open banks and raises prechargeEvt for each of them. Banks are closed from the next cycle, and a burst owned by a closed bank ends.
- R8: A legal READ or WRITE to bank m, while an auto-precharge burst to a different bank n is in flight, raises prechargeEvt for bank n in that cycle. Bank n is closed from the next cycle, and the new burst then belongs to bank m.
- R9: AUTO REFRESH and MODE REGISTER SET are legal only while every bank is closed. When any bank is open they raise cmdIllegal. Neither one changes bank state.
- R10: During and after reset all banks read closed and burstValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low; high masks the command |
| rasN | input | 1 | Row strobe command pin, active low |
| casN | input | 1 | Column strobe command pin, active low |
| weN | input | 1 | Write enable command pin, active low |
| bankAddr | input | 2 | Target bank of the command |
| a10 | input | 1 | All-bank select on PRECHARGE, auto precharge on READ/WRITE |
| cmdOut | output | 3 | Decoded command code for this cycle (codes in R1) |
| cmdIllegal | output | 1 | Command does not fit the state of its target |
| prechargeEvt | output | 4 | One bit per bank: that bank starts precharging this cycle |
| bankActive | output | 4 | One bit per bank: bank is open |
| burstValid | output | 1 | A burst is in flight |
| burstBank | output | 2 | Bank that owns the burst in flight |

## Verification
Two functions can close banks in the same cycle: the natural end of an auto-precharge burst, and an explicit PRECHARGE or an interrupting access to another bank. The bench lands a PRECHARGE with A10 high exactly on the last cycle of an auto-precharge burst, while a second bank is also open. It then checks that prechargeEvt carries the union of both sources, with the burst's bank appearing once, and that every bank is closed with no burst left in the next cycle. It also places an interrupting READ one cycle into an auto-precharge burst. There it judges that the old bank's event appears alongside the legal new command and that the burst record then moves to the new bank.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int SD_BANKS = 4;
  localparam int SD_BANK_BITS = $clog2(SD_BANKS);

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ACT     = 3'd1,
    CMD_READ    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_TERM    = 3'd4,
    CMD_PRE     = 3'd5,
    CMD_REFRESH = 3'd6,
    CMD_MODESET = 3'd7
  } cmd_e;

  // Strobes from the control to the bank/burst datapath
  typedef struct packed {
    logic [SD_BANKS-1:0]     openMask;
    logic [SD_BANKS-1:0]     closeMask;
    logic                    startBurst;
    logic [SD_BANK_BITS-1:0] startBank;
    logic                    startAp;
    logic                    stopBurst;
  } strobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    csN,
  input  logic                    rasN,
  input  logic                    casN,
  input  logic                    weN,
  input  logic [SD_BANK_BITS-1:0] bankAddr,
  input  logic                    a10,
  input  logic [SD_BANKS-1:0]     bankActive,
  input  logic                    burstValid,
  input  logic [SD_BANK_BITS-1:0] burstBank,
  input  logic                    burstAp,
  input  logic                    burstLast,
  output cmd_e                    cmd,
  output logic                    cmdIllegal,
  output strobe_t                 strobe
);

  logic [SD_BANKS-1:0] tgtMask, burstMask, apMask, preMask;
  logic tgtOpen, apPendTgt, isAccess, legalAccess, otherBank;

  always_comb begin
    if (csN) cmd = CMD_NOP;
    else begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_TERM;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REFRESH;
        3'b000:  cmd = CMD_MODESET;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign tgtMask   = SD_BANKS'(1) << bankAddr;
  assign burstMask = SD_BANKS'(1) << burstBank;
  assign tgtOpen   = bankActive[bankAddr];
  assign apPendTgt = burstValid && burstAp && (burstBank == bankAddr);
  assign isAccess  = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign otherBank = burstValid && (burstBank != bankAddr);

  always_comb begin
    case (cmd)
      CMD_ACT:                  cmdIllegal = tgtOpen;
      CMD_READ, CMD_WRITE:      cmdIllegal = !tgtOpen || apPendTgt;
      CMD_REFRESH, CMD_MODESET: cmdIllegal = |bankActive;
      default:                  cmdIllegal = 1'b0;
    endcase
  end

  assign legalAccess = isAccess && !cmdIllegal;

  // Auto precharge: burst end, or interruption by an access to another bank
  assign apMask  = (burstValid && burstAp && (burstLast || (legalAccess && otherBank)))
                   ? burstMask : '0;
  assign preMask = (cmd == CMD_PRE) ? ((a10 ? {SD_BANKS{1'b1}} : tgtMask) & bankActive) : '0;

  always_comb begin
    strobe.openMask   = (cmd == CMD_ACT && !cmdIllegal) ? tgtMask : '0;
    strobe.closeMask  = apMask | preMask;
    strobe.startBurst = legalAccess;
    strobe.startBank  = bankAddr;
    strobe.startAp    = a10;
    strobe.stopBurst  = (cmd == CMD_TERM) || burstLast ||
                        (burstValid && (|(preMask & burstMask)));
  end

  assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (cmd == CMD_NOP) && !cmdIllegal);

  assert_evt_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.closeMask & ~bankActive) == '0);

  assert_refresh_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd == CMD_REFRESH || cmd == CMD_MODESET) && (|bankActive)) |-> cmdIllegal);

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  output logic [SD_BANKS-1:0]     bankActive,
  output logic                    burstValid,
  output logic [SD_BANK_BITS-1:0] burstBank,
  output logic                    burstAp,
  output logic                    burstLast
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] burstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bankActive <= '0;
    else       bankActive <= (bankActive & ~strobe.closeMask) | strobe.openMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstValid <= 1'b0;
      burstBank  <= '0;
      burstAp    <= 1'b0;
      burstCnt   <= '0;
    end else if (strobe.startBurst) begin
      burstValid <= 1'b1;
      burstBank  <= strobe.startBank;
      burstAp    <= strobe.startAp;
      burstCnt   <= CNT_LOAD;
    end else if (strobe.stopBurst) begin
      burstValid <= 1'b0;
      burstAp    <= 1'b0;
      burstCnt   <= '0;
    end else if (burstValid) begin
      burstCnt <= burstCnt - CNT_ONE;
    end
  end

  assign burstLast = burstValid && (burstCnt == CNT_ONE);

  assert_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.openMask) |=> ((bankActive & $past(strobe.openMask)) == $past(strobe.openMask)));

  assert_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.closeMask) |=> ((bankActive & $past(strobe.closeMask)) == '0));

  assert_burst_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> bankActive[burstBank]);

  assert_burst_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (burstLast && !strobe.startBurst) |=> !burstValid);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    csN,
  input  logic                    rasN,
  input  logic                    casN,
  input  logic                    weN,
  input  logic [SD_BANK_BITS-1:0] bankAddr,
  input  logic                    a10,
  output logic [2:0]              cmdOut,
  output logic                    cmdIllegal,
  output logic [SD_BANKS-1:0]     prechargeEvt,
  output logic [SD_BANKS-1:0]     bankActive,
  output logic                    burstValid,
  output logic [SD_BANK_BITS-1:0] burstBank
);
  cmd_e    cmd;
  strobe_t strobe;
  logic    burstAp, burstLast;

  sdcmd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .a10(a10), .bankActive(bankActive),
    .burstValid(burstValid), .burstBank(burstBank), .burstAp(burstAp),
    .burstLast(burstLast), .cmd(cmd), .cmdIllegal(cmdIllegal), .strobe(strobe)
  );

  sdcmd_bank #(.BURST_LEN(BURST_LEN)) i_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankActive(bankActive),
    .burstValid(burstValid), .burstBank(burstBank), .burstAp(burstAp),
    .burstLast(burstLast)
  );

  assign cmdOut       = cmd;
  assign prechargeEvt = strobe.closeMask;
endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, a10 = 1'b0;
  logic [1:0] bankAddr = '0;
  logic [2:0] cmdOut;
  logic cmdIllegal, burstValid;
  logic [3:0] prechargeEvt, bankActive;
  logic [1:0] burstBank;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker #(.BURST_LEN(4)) i_sdram_cmd_tracker (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .a10(a10), .cmdOut(cmdOut), .cmdIllegal(cmdIllegal),
    .prechargeEvt(prechargeEvt), .bankActive(bankActive),
    .burstValid(burstValid), .burstBank(burstBank)
  );

  // {csN,rasN,casN,weN, ba[1:0], a10, expCmd[2:0], expIll, expEvt[3:0], expActAfter[3:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {4'b1000, 2'd0, 1'b0, 3'd0, 1'b0, 4'b0000, 4'b0000},  // R1 masked
    {4'b0111, 2'd0, 1'b0, 3'd0, 1'b0, 4'b0000, 4'b0000},  // R1 NOP
    {4'b0011, 2'd1, 1'b0, 3'd1, 1'b0, 4'b0000, 4'b0010},  // R2 ACT b1
    {4'b0011, 2'd1, 1'b0, 3'd1, 1'b1, 4'b0000, 4'b0010},  // R2 ACT open
    {4'b0101, 2'd0, 1'b0, 3'd2, 1'b1, 4'b0000, 4'b0010},  // R3 RD closed
    {4'b0001, 2'd0, 1'b0, 3'd6, 1'b1, 4'b0000, 4'b0010},  // R9 REF busy
    {4'b0000, 2'd0, 1'b0, 3'd7, 1'b1, 4'b0000, 4'b0010},  // R9 MRS busy
    {4'b0010, 2'd0, 1'b0, 3'd5, 1'b0, 4'b0000, 4'b0010},  // R7 PRE closed
    {4'b0010, 2'd1, 1'b0, 3'd5, 1'b0, 4'b0010, 4'b0000},  // R7 PRE b1
    {4'b0001, 2'd0, 1'b0, 3'd6, 1'b0, 4'b0000, 4'b0000},  // R9 REF idle
    {4'b0000, 2'd2, 1'b0, 3'd7, 1'b0, 4'b0000, 4'b0000},  // R9 MRS idle
    {4'b0011, 2'd3, 1'b0, 3'd1, 1'b0, 4'b0000, 4'b1000},  // R2 ACT b3
    {4'b0011, 2'd2, 1'b0, 3'd1, 1'b0, 4'b0000, 4'b1100},  // R2 ACT b2
    {4'b0100, 2'd2, 1'b0, 3'd3, 1'b0, 4'b0000, 4'b1100},  // R4 WR b2
    {4'b0110, 2'd0, 1'b0, 3'd4, 1'b0, 4'b0000, 4'b1100},  // R6 BST
    {4'b0010, 2'd0, 1'b1, 3'd5, 1'b0, 4'b1100, 4'b0000}   // R7 PRE all
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic c, r, ca, w, input logic [1:0] ba, input logic a);
    @(negedge clk);
    csN = c; rasN = r; casN = ca; weN = w; bankAddr = ba; a10 = a;
    #1;
  endtask

  task automatic nop();                           apply(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0); endtask
  task automatic act(input logic [1:0] ba);       apply(1'b0, 1'b0, 1'b1, 1'b1, ba, 1'b0);   endtask
  task automatic rd(input logic [1:0] ba, input logic ap); apply(1'b0, 1'b1, 1'b0, 1'b1, ba, ap); endtask
  task automatic wr(input logic [1:0] ba, input logic ap); apply(1'b0, 1'b1, 1'b0, 1'b0, ba, ap); endtask
  task automatic bst(input logic [1:0] ba);       apply(1'b0, 1'b1, 1'b1, 1'b0, ba, 1'b0);   endtask
  task automatic pre(input logic [1:0] ba, input logic all); apply(1'b0, 1'b0, 1'b1, 1'b0, ba, all); endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 bankActive in reset", bankActive, 0);
    chk("R10 burstValid in reset", burstValid, 0);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R10 bankActive after reset", bankActive, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      v = VEC[i];
      apply(v[18], v[17], v[16], v[15], v[14:13], v[12]);
      chk($sformatf("R1 cmd vec%0d", i), cmdOut, v[11:9]);
      chk($sformatf("R2/R3/R9 illegal vec%0d", i), cmdIllegal, v[8]);
      chk($sformatf("R7 evt vec%0d", i), prechargeEvt, v[7:4]);
      @(posedge clk); #1;
      chk($sformatf("R2/R7 bankActive after vec%0d", i), bankActive, v[3:0]);
      if (i == 13) chk("R4 burst after WR", {burstValid, burstBank}, 6);
      if (i == 14) chk("R6 burst ended by BST", burstValid, 0);
    end

    // R4/R5: auto-precharge read runs to completion; R3 access to its bank refused
    act(2'd0);
    rd(2'd0, 1'b1);
    chk("R4 RD legal", cmdIllegal, 0);
    for (int k = 1; k <= 4; k++) begin
      if (k == 2) begin
        wr(2'd0, 1'b0);
        chk("R3 WR to bank with pending auto precharge", cmdIllegal, 1);
      end else nop();
      chk($sformatf("R4 burstValid k%0d", k), burstValid, 1);
      chk($sformatf("R4 burstBank k%0d", k), burstBank, 0);
      chk($sformatf("R5 evt k%0d", k), prechargeEvt, (k == 4) ? 1 : 0);
    end
    nop();
    chk("R5 burst over", burstValid, 0);
    chk("R5 bank closed", bankActive, 0);

    // R8: interrupt an auto-precharge burst with an access to another bank
    act(2'd1);
    act(2'd2);
    rd(2'd1, 1'b1);
    nop();
    chk("R8 burst owner b1", burstBank, 1);
    rd(2'd2, 1'b0);
    chk("R8 interrupting RD legal", cmdIllegal, 0);
    chk("R8 evt for interrupted bank", prechargeEvt, 4'b0010);
    nop();
    chk("R8 bank1 closed", bankActive, 4'b0100);
    chk("R8 burst moved to b2", {burstValid, burstBank}, 6);
    bst(2'd3);
    chk("R6 BST cmd", cmdOut, 4);
    chk("R6 BST no evt", prechargeEvt, 0);
    nop();
    chk("R6 burst ended regardless of bank", burstValid, 0);
    chk("R6 banks stay open", bankActive, 4'b0100);

    // Overlap: PRECHARGE all on the last cycle of an auto-precharge burst
    act(2'd3);
    rd(2'd3, 1'b1);
    nop(); nop(); nop();
    pre(2'd0, 1'b1);
    chk("R5/R7 overlap evt union", prechargeEvt, 4'b1100);
    chk("R7 overlap legal", cmdIllegal, 0);
    nop();
    chk("R5/R7 overlap all closed", bankActive, 0);
    chk("R5/R7 overlap burst gone", burstValid, 0);

    // R7: single-bank precharge ends the burst its bank owns
    act(2'd0);
    rd(2'd0, 1'b0);
    pre(2'd0, 1'b0);
    chk("R7 single evt", prechargeEvt, 4'b0001);
    nop();
    chk("R7 burst cut by precharge", burstValid, 0);
    chk("R7 bank0 closed", bankActive, 0);

    // R1: chip select high masks a would-be ACTIVE
    apply(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0);
    chk("R1 masked cmd", cmdOut, 0);
    nop();
    chk("R1 masked no open", bankActive, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule